// File: doc/BRIEF.md
# Trace Capture Controller

This block runs in the processor clock domain and decides which cycles of program execution produce trace samples. It watches the watchpoint lines, the breakpoint line, the load/store status lines and the instruction status lines. Two configurable condition expressions decide when a sample is taken. The trigger expression arms recording, and once it has fired it stays armed. The qualifier expression then picks the individual cycles that are recorded. A third expression of the same format, the stop expression, disarms recording.

On each recorded cycle, a record-select mask names the kinds of sample to store: program counter, load/store effective address, store data and load data. The selected values are captured at once. They are then written one per clock, lowest kind first, into a small internal ring of 40-bit entries. During that time the block asks the processor to stall. Software writes the five 32-bit configuration words over a plain register port and can read them back on the same port. The ring can be read through a combinational peek port.

The sample write path has no back-pressure. The ring always accepts a write, so `rec_stb_o` is a plain strobe with no ready. The processor must honour `stall_o` so that no new cycle reaches the block while samples are pending.

Top module: `trc_unit`

## Requirements
- R1: After reset, all five configuration words read as zero, `rec_stb_o` and `stall_o` are low and `rec_ptr_o` is zero.
- R2: A write with `cfg_we` high at address 0 (mode), 1 (trigger), 2 (qualifier), 3 (stop) or 4 (record select) stores all 32 bits, and `cfg_rdata` returns the addressed word combinationally. Writes to any other address, and cycles with `cfg_we` low, change no word, and reads of other addresses return zero.
- R3: While mode bit 0 is clear, no new recording starts and `stall_o` stays low once pending samples have drained.
- R4: The trigger, qualifier and stop words share one format. Bits 10:0 are a watchpoint mask, and the watchpoint group is true when any masked watchpoint line is high. Bit 11 is that group's valid bit. Bits 15:12 are a load/store status mask, and that group is true when every masked status bit is high. Bit 16 is that group's valid bit. Bit 17 makes the breakpoint input a group. When no valid bit is set, the trigger and the qualifier are always true and the stop is always false.
- R5: Bit 18 of a condition word selects AND (1) or OR (0) across the valid groups.
- R6: A trigger that fires while enabled is latched. Later cycles count as triggered until the stop condition is true or mode bit 0 is cleared.
- R7: A cycle starts recording only if it is enabled, triggered (latched or firing now), qualified, not stopped, not already pending, and the record mask is non-zero.
- R8: Record mask bit k selects kind k: 0 program counter, 1 effective address, 2 store data, 3 load data. The values and `istat_i` are captured in the qualified cycle. Starting in the next cycle, one selected kind is written per clock in ascending order, with `rec_kind_o` equal to k. Each entry is {sample[31:0], 4'b0, istat[1:0], kind[1:0]}.
- R9: `rec_ptr_o` is the entry written on a strobe. It advances by one after each strobe and wraps from DEPTH-1 to 0.
- R10: `stall_o` is high in the qualified cycle and in every cycle with a pending write, and low otherwise.
- R11: A true stop condition blocks recording in its cycle and clears the trigger latch.
- R12: With a zero record mask, no sample is written and no stall is requested.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Processor clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write enable |
| cfg_addr | input | 5 | Configuration word address |
| cfg_wdata | input | 32 | Configuration write data |
| cfg_rdata | output | 32 | Addressed configuration word |
| watch_i | input | 11 | Watchpoint lines |
| brk_i | input | 1 | Breakpoint line |
| lsst_i | input | 4 | Load/store status |
| istat_i | input | 2 | Instruction status, stored with each entry |
| pc_i | input | 32 | Program counter value |
| lsea_i | input | 32 | Load/store effective address |
| stdat_i | input | 32 | Store data |
| lddat_i | input | 32 | Load data |
| rec_stb_o | output | 1 | An entry is written this cycle |
| rec_ptr_o | output | 3 | Entry index being written |
| rec_kind_o | output | 2 | Kind of the entry being written |
| stall_o | output | 1 | Processor stall request |
| peek_addr_i | input | 3 | Ring entry to read |
| peek_data_o | output | 40 | Content of the addressed ring entry |

## Verification
A wrong trigger latch shows up in the same cycle as a `stall_o` that should or should not be there, because the qualified cycle raises the stall combinationally. A corrupted pending set shows up within one clock, as a wrong `rec_kind_o`, a missing strobe, or a stall that never drops. A pointer fault shows up at the next strobe, as a wrong `rec_ptr_o`. A capture fault shows up on the peek port one clock after the strobe that wrote the entry.

// File: rtl/trc_pkg.sv
package trc_pkg;
  localparam int CFG_AW  = 5;
  localparam int CFG_DW  = 32;
  localparam int NREG    = 5;
  localparam int REG_IW  = $clog2(NREG);
  localparam int WATCH_W = 11;
  localparam int LSST_W  = 4;
  localparam int ISTAT_W = 2;
  localparam int SAMP_W  = 32;
  localparam int NKIND   = 4;
  localparam int KIND_W  = $clog2(NKIND);
  localparam int ENTRY_W = 40;

  // configuration word indices
  localparam int R_MODE = 0;
  localparam int R_TRIG = 1;
  localparam int R_QUAL = 2;
  localparam int R_STOP = 3;
  localparam int R_REC  = 4;

  localparam int MODE_EN_BIT = 0;

  // condition word fields
  localparam int F_WP_LO  = 0;
  localparam int F_WP_VLD = 11;
  localparam int F_LS_LO  = 12;
  localparam int F_LS_VLD = 16;
  localparam int F_BP_VLD = 17;
  localparam int F_OP_AND = 18;
endpackage

// File: rtl/trc_cond.sv
module trc_cond import trc_pkg::*; #(
  parameter bit EMPTY_TRUE = 1'b1
) (
  input  logic [CFG_DW-1:0]  sel,
  input  logic [WATCH_W-1:0] watch,
  input  logic               brk,
  input  logic [LSST_W-1:0]  lsst,
  output logic               hit
);
  localparam int NGRP = 3;

  logic [WATCH_W-1:0] wmask;
  logic [LSST_W-1:0]  lmask;
  logic [NGRP-1:0]    vld;
  logic [NGRP-1:0]    grp;

  assign wmask = sel[F_WP_LO +: WATCH_W];
  assign lmask = sel[F_LS_LO +: LSST_W];
  assign vld   = {sel[F_BP_VLD], sel[F_LS_VLD], sel[F_WP_VLD]};
  assign grp   = {brk, ((lsst & lmask) == lmask), |(watch & wmask)};

  always_comb begin
    if (vld == '0)
      hit = EMPTY_TRUE;
    else if (sel[F_OP_AND])
      hit = &(grp | ~vld);
    else
      hit = |(grp & vld);
  end
endmodule

// File: rtl/trc_seq.sv
module trc_seq import trc_pkg::*; (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic                          fire,
  input  logic [NKIND-1:0]              mask,
  input  logic [NKIND-1:0][SAMP_W-1:0]  src,
  input  logic [ISTAT_W-1:0]            istat,
  output logic                          stb,
  output logic [KIND_W-1:0]             kind,
  output logic [ENTRY_W-1:0]            entry
);
  localparam int PAD_W = ENTRY_W - SAMP_W - ISTAT_W - KIND_W;

  logic [NKIND-1:0]             pend_q;
  logic [NKIND-1:0]             done_bit;
  logic [NKIND-1:0][SAMP_W-1:0] hold_q;
  logic [ISTAT_W-1:0]           ist_q;

  // lowest pending kind goes first
  always_comb begin
    kind = '0;
    for (int k = NKIND - 1; k >= 0; k--)
      if (pend_q[k]) kind = KIND_W'(k);
  end

  assign done_bit = NKIND'(1) << kind;
  assign stb      = |pend_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pend_q <= '0;
    else if (fire)
      pend_q <= mask;
    else
      pend_q <= pend_q & ~done_bit;
  end

  always_ff @(posedge clk) begin
    if (fire) begin
      hold_q <= src;
      ist_q  <= istat;
    end
  end

  assign entry = {hold_q[kind], {PAD_W{1'b0}}, ist_q, kind};
endmodule

// File: rtl/trc_store.sv
module trc_store import trc_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr,
  input  logic [ENTRY_W-1:0] entry,
  output logic [PW-1:0]      ptr,
  input  logic [PW-1:0]      peek_addr,
  output logic [ENTRY_W-1:0] peek_data
);
  logic [ENTRY_W-1:0] mem [DEPTH];
  logic [PW-1:0]      ptr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      ptr_q <= '0;
    else if (wr)
      ptr_q <= (ptr_q == PW'(DEPTH - 1)) ? '0 : ptr_q + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (wr) mem[ptr_q] <= entry;
  end

  assign ptr       = ptr_q;
  assign peek_data = mem[peek_addr];
endmodule

// File: rtl/trc_unit.sv
module trc_unit import trc_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cfg_we,
  input  logic [CFG_AW-1:0]  cfg_addr,
  input  logic [CFG_DW-1:0]  cfg_wdata,
  output logic [CFG_DW-1:0]  cfg_rdata,
  input  logic [WATCH_W-1:0] watch_i,
  input  logic               brk_i,
  input  logic [LSST_W-1:0]  lsst_i,
  input  logic [ISTAT_W-1:0] istat_i,
  input  logic [SAMP_W-1:0]  pc_i,
  input  logic [SAMP_W-1:0]  lsea_i,
  input  logic [SAMP_W-1:0]  stdat_i,
  input  logic [SAMP_W-1:0]  lddat_i,
  output logic               rec_stb_o,
  output logic [PW-1:0]      rec_ptr_o,
  output logic [KIND_W-1:0]  rec_kind_o,
  output logic               stall_o,
  input  logic [PW-1:0]      peek_addr_i,
  output logic [ENTRY_W-1:0] peek_data_o
);
  localparam int NCOND  = 3;
  localparam int C_TRIG = 0;
  localparam int C_QUAL = 1;
  localparam int C_STOP = 2;

  logic [CFG_DW-1:0]  cfg_q [NREG];
  logic               cfg_hit;
  logic [NCOND-1:0]   hit;
  logic               mode_en;
  logic               trig_q;
  logic               triggered;
  logic               fire;
  logic [NKIND-1:0]   rec_mask;
  logic [ENTRY_W-1:0] entry;

  // configuration words
  assign cfg_hit = cfg_addr < CFG_AW'(NREG);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int r = 0; r < NREG; r++) cfg_q[r] <= '0;
    end else if (cfg_we && cfg_hit) begin
      cfg_q[cfg_addr[REG_IW-1:0]] <= cfg_wdata;
    end
  end

  assign cfg_rdata = cfg_hit ? cfg_q[cfg_addr[REG_IW-1:0]] : '0;
  assign mode_en   = cfg_q[R_MODE][MODE_EN_BIT];
  assign rec_mask  = cfg_q[R_REC][NKIND-1:0];

  // trigger, qualifier and stop share one evaluator; only the empty value differs
  for (genvar g = 0; g < NCOND; g++) begin : g_cond
    trc_cond #(.EMPTY_TRUE(g != C_STOP)) u_cond (
      .sel   (cfg_q[R_TRIG + g]),
      .watch (watch_i),
      .brk   (brk_i),
      .lsst  (lsst_i),
      .hit   (hit[g])
    );
  end

  assign triggered = trig_q | hit[C_TRIG];
  assign fire      = mode_en & ~hit[C_STOP] & triggered & hit[C_QUAL]
                   & ~rec_stb_o & (|rec_mask);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      trig_q <= 1'b0;
    else
      trig_q <= mode_en & ~hit[C_STOP] & triggered;
  end

  trc_seq u_seq (
    .clk   (clk),
    .rst_n (rst_n),
    .fire  (fire),
    .mask  (rec_mask),
    .src   ({lddat_i, stdat_i, lsea_i, pc_i}),
    .istat (istat_i),
    .stb   (rec_stb_o),
    .kind  (rec_kind_o),
    .entry (entry)
  );

  trc_store #(.DEPTH(DEPTH)) u_store (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr        (rec_stb_o),
    .entry     (entry),
    .ptr       (rec_ptr_o),
    .peek_addr (peek_addr_i),
    .peek_data (peek_data_o)
  );

  assign stall_o = fire | rec_stb_o;
endmodule

// File: rtl/trc_unit_chk.sv
module trc_unit_chk import trc_pkg::*; #(
  parameter int DEPTH = 8,
  localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              mode_en,
  input logic              rec_stb_o,
  input logic [PW-1:0]     rec_ptr_o,
  input logic [KIND_W-1:0] rec_kind_o,
  input logic              stall_o
);
  logic [PW-1:0] nxt_ptr;
  assign nxt_ptr = (rec_ptr_o == PW'(DEPTH - 1)) ? '0 : rec_ptr_o + 1'b1;

  // R9: pointer advances by one (with wrap) after every strobe
  p_ptr_step_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb_o |=> rec_ptr_o == $past(nxt_ptr));

  // R9: pointer holds when nothing is written
  p_ptr_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !rec_stb_o |=> $stable(rec_ptr_o));

  // R10: a pending write always comes with a stall request
  p_stall_cover_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb_o |-> stall_o);

  // R8: back-to-back strobes carry strictly ascending kinds
  p_kind_order_r8: assert property (@(posedge clk) disable iff (!rst_n)
    rec_stb_o |=> (!rec_stb_o || rec_kind_o > $past(rec_kind_o)));

  // R3: disabled and idle means no strobe in the next cycle
  p_idle_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!mode_en && !stall_o) |=> !rec_stb_o);
endmodule

bind trc_unit trc_unit_chk #(.DEPTH(DEPTH)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .mode_en    (mode_en),
  .rec_stb_o  (rec_stb_o),
  .rec_ptr_o  (rec_ptr_o),
  .rec_kind_o (rec_kind_o),
  .stall_o    (stall_o)
);

// File: tb/trc_unit_tb.sv
module trc_unit_tb;
  localparam int DEPTH = 8;
  localparam int PW    = 3;

  localparam logic [31:0] WP_VLD  = 32'h0000_0800;
  localparam logic [31:0] LS_VLD  = 32'h0001_0000;
  localparam logic [31:0] BP_VLD  = 32'h0002_0000;
  localparam logic [31:0] OP_AND  = 32'h0004_0000;
  localparam logic [31:0] WP4     = 32'h0000_0010;
  localparam logic [31:0] LS_0_2  = 32'h0000_5000;

  // {we, addr, data, expected readback}
  localparam logic [69:0] VEC [9] = '{
    {1'b1, 5'd0,  32'hA5A5_A5A4, 32'hA5A5_A5A4},
    {1'b1, 5'd1,  32'h0001_2345, 32'h0001_2345},
    {1'b1, 5'd2,  32'h0000_0300, 32'h0000_0300},
    {1'b1, 5'd3,  32'h0000_4000, 32'h0000_4000},
    {1'b1, 5'd4,  32'h0000_DEA0, 32'h0000_DEA0},
    {1'b1, 5'd5,  32'h1234_5678, 32'h0000_0000},
    {1'b1, 5'd31, 32'hFFFF_FFFF, 32'h0000_0000},
    {1'b0, 5'd1,  32'hFFFF_FFFF, 32'h0001_2345},
    {1'b0, 5'd4,  32'h0000_0000, 32'h0000_DEA0}
  };

  logic        clk, rst_n;
  logic        cfg_we;
  logic [4:0]  cfg_addr;
  logic [31:0] cfg_wdata, cfg_rdata;
  logic [10:0] watch;
  logic        brk;
  logic [3:0]  lsst;
  logic [1:0]  istat;
  logic [31:0] pc, ea, sd, ld;
  logic        rec_stb, stall;
  logic [PW-1:0] rec_ptr, peek_addr;
  logic [1:0]  rec_kind;
  logic [39:0] peek_data;

  int n_chk = 0;
  int n_fail = 0;
  int exp_ptr = 0;
  logic done = 1'b0;

  trc_unit #(.DEPTH(DEPTH)) u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .watch_i(watch),
    .brk_i(brk), .lsst_i(lsst), .istat_i(istat), .pc_i(pc), .lsea_i(ea),
    .stdat_i(sd), .lddat_i(ld), .rec_stb_o(rec_stb), .rec_ptr_o(rec_ptr),
    .rec_kind_o(rec_kind), .stall_o(stall), .peek_addr_i(peek_addr),
    .peek_data_o(peek_data)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic cfg_write(input logic [4:0] a, input logic [31:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic strobe_kind0(input string req);
    check(req, "strobe", rec_stb, 1);
    check(req, "kind", rec_kind, 0);
    check("R9", "pointer", rec_ptr, exp_ptr);
    exp_ptr = (exp_ptr + 1) % DEPTH;
  endtask

  // qualified cycle via breakpoint, then walk the selected kinds
  task automatic burst(input logic [3:0] mask, input logic [31:0] base, input logic [1:0] ist);
    logic [31:0] vals [4];
    logic        have_prev;
    int          prev_ptr;
    logic [39:0] prev_exp;
    have_prev = 1'b0;
    prev_ptr = 0;
    prev_exp = '0;
    for (int k = 0; k < 4; k++) vals[k] = base + k;
    pc = vals[0]; ea = vals[1]; sd = vals[2]; ld = vals[3]; istat = ist; brk = 1'b1;
    #1;
    check("R10", "stall in qualified cycle", stall, 1);
    check("R8", "no strobe in qualified cycle", rec_stb, 0);
    for (int k = 0; k < 4; k++) begin
      if (mask[k]) begin
        @(negedge clk);
        brk = 1'b0; pc = ~base; ea = ~base; sd = ~base; ld = ~base; istat = ~ist;
        #1;
        if (have_prev) begin
          peek_addr = PW'(prev_ptr); #1;
          check("R8", "entry content", peek_data, prev_exp);
        end
        check("R8", "strobe", rec_stb, 1);
        check("R8", "kind order", rec_kind, k);
        check("R9", "pointer", rec_ptr, exp_ptr);
        check("R10", "stall while pending", stall, 1);
        have_prev = 1'b1;
        prev_ptr = exp_ptr;
        prev_exp = {vals[k], 4'b0, ist, 2'(k)};
        exp_ptr = (exp_ptr + 1) % DEPTH;
      end
    end
    @(negedge clk);
    brk = 1'b0; #1;
    peek_addr = PW'(prev_ptr); #1;
    check("R8", "last entry content", peek_data, prev_exp);
    check("R10", "stall released", stall, 0);
    check("R8", "burst ended", rec_stb, 0);
  endtask

  initial begin
    rst_n = 1'b0; cfg_we = 1'b0; cfg_addr = '0; cfg_wdata = '0;
    watch = '0; brk = 1'b0; lsst = '0; istat = '0;
    pc = '0; ea = '0; sd = '0; ld = '0; peek_addr = '0;
    repeat (3) @(negedge clk);
    #1;
    check("R1", "strobe in reset", rec_stb, 0);
    check("R1", "stall in reset", stall, 0);
    check("R1", "pointer in reset", rec_ptr, 0);
    check("R1", "mode word", cfg_rdata, 0);
    rst_n = 1'b1;
    @(negedge clk);
    cfg_addr = 5'd4; #1;
    check("R1", "record word", cfg_rdata, 0);
    check("R1", "stall after reset", stall, 0);

    // R2: register port vector walk
    for (int i = 0; i < 9; i++) begin
      logic [69:0] v;
      v = VEC[i];
      cfg_we = v[69]; cfg_addr = v[68:64]; cfg_wdata = v[63:32];
      @(negedge clk);
      cfg_we = 1'b0; #1;
      check("R2", "readback", cfg_rdata, v[31:0]);
    end

    // R3: disabled with always-true conditions
    cfg_write(5'd1, 32'h0);
    cfg_write(5'd2, 32'h0);
    cfg_write(5'd3, 32'h0);
    cfg_write(5'd4, 32'h1);
    cfg_write(5'd0, 32'h0);
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R3", "stall while disabled", stall, 0);
      check("R3", "strobe while disabled", rec_stb, 0);
      @(negedge clk);
    end

    // R7 R8 R9 R10: breakpoint-qualified bursts
    cfg_write(5'd2, BP_VLD);
    cfg_write(5'd4, 32'hF);
    cfg_write(5'd0, 32'h1);
    #1;
    check("R7", "unqualified cycle", stall, 0);
    burst(4'hF, 32'h1000_0000, 2'b10);
    cfg_write(5'd4, 32'hA);
    burst(4'hA, 32'h2000_0000, 2'b01);
    cfg_write(5'd4, 32'h5);
    burst(4'h5, 32'h3000_0000, 2'b11);
    cfg_write(5'd4, 32'h1);
    burst(4'h1, 32'h4000_0000, 2'b00);
    check("R9", "wrapped pointer", rec_ptr, 1);

    // R5 R6 R11: AND trigger, latch, stop
    cfg_write(5'd0, 32'h0);
    cfg_write(5'd2, 32'h0);
    cfg_write(5'd1, WP4 | WP_VLD | LS_0_2 | LS_VLD | OP_AND);
    cfg_write(5'd3, BP_VLD);
    cfg_write(5'd0, 32'h1);
    #1;
    check("R6", "not yet triggered", stall, 0);
    @(negedge clk); watch = 11'h010; lsst = 4'b0001; #1;
    check("R5", "AND with partial status", stall, 0);
    @(negedge clk); lsst = 4'b0101; #1;
    check("R5", "AND satisfied", stall, 1);
    @(negedge clk); watch = '0; lsst = '0; #1;
    strobe_kind0("R7");
    @(negedge clk); #1;
    check("R6", "latched trigger qualifies", stall, 1);
    check("R6", "no strobe in qualified cycle", rec_stb, 0);
    @(negedge clk); #1;
    strobe_kind0("R6");
    @(negedge clk); brk = 1'b1; #1;
    check("R11", "stop blocks cycle", stall, 0);
    @(negedge clk); brk = 1'b0; #1;
    check("R11", "latch cleared by stop", stall, 0);
    check("R11", "no strobe after stop", rec_stb, 0);

    // R4 R5: OR trigger
    cfg_write(5'd0, 32'h0);
    cfg_write(5'd3, 32'h0);
    cfg_write(5'd1, WP4 | WP_VLD | LS_0_2 | LS_VLD);
    cfg_write(5'd0, 32'h1);
    lsst = 4'b0100; #1;
    check("R5", "OR with incomplete status", stall, 0);
    @(negedge clk); lsst = '0; watch = 11'h008; #1;
    check("R4", "unmasked watchpoint", stall, 0);
    @(negedge clk); watch = 11'h010; #1;
    check("R5", "OR via watchpoint", stall, 1);
    @(negedge clk); watch = '0; #1;
    strobe_kind0("R5");
    cfg_write(5'd0, 32'h0);
    #1;
    check("R3", "disable stops recording", stall, 0);
    check("R3", "pointer unchanged", rec_ptr, exp_ptr);

    // R12 then R4: empty mask, then zero conditions always true
    cfg_write(5'd1, 32'h0);
    cfg_write(5'd4, 32'h0);
    cfg_write(5'd0, 32'h1);
    for (int i = 0; i < 3; i++) begin
      #1;
      check("R12", "no stall with empty mask", stall, 0);
      check("R12", "pointer still", rec_ptr, exp_ptr);
      @(negedge clk);
    end
    cfg_write(5'd4, 32'h1);
    #1;
    check("R4", "zero trigger and qualifier fire", stall, 1);
    @(negedge clk); #1;
    strobe_kind0("R4");
    cfg_write(5'd0, 32'h0);
    #1;
    check("R3", "idle after disable", stall, 0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog R10: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule